// File: doc/BRIEF.md
# Four-Format Serial Master with Queued Words and Interrupt Flags

This block is a serial peripheral master that moves 16-bit words. Software talks to it through a small register bus with four word addresses. Writing a word to the data address places it in a transmit queue. While the block is switched on, the engine takes the oldest queued word and shifts it out on `spi_mosi`, most significant bit first. It drives the serial clock and pulls `spi_ss_n` low for the frame. At the same time it assembles the word arriving on `spi_miso`. Each finished word goes into a receive queue, and a read of the data address returns and removes the oldest one. Clock idle level and sampling phase are set by two control bits, so all four clock formats are covered. The half period of the serial clock is the parameter `CLK_DIV`, counted in system clock cycles.

A queue-mode control bit selects the queue depth. With the bit set, each queue holds `FIFO_DEPTH` (8) words and the nearly-empty and nearly-full thresholds apply. With it clear, each side is a single-word buffer. A status word reports empty, nearly empty and full for the transmit side, and empty, nearly full and full for the receive side. It also reports a software-clearable error flag and a sticky overflow flag for each queue. Four interrupt-pending bits feed the `irq` output. In queue mode a write-one-to-clear register clears them. In single-word mode they follow their conditions directly and the clear register is ignored.

The bus is a plain strobe interface with no back-pressure: `bus_en` with `bus_we` high is a write that takes effect at that clock edge. `bus_en` with `bus_we` low is a read. `bus_rdata` shows the addressed value in the same cycle, and a read of the data address pops the receive queue at the clock edge. A write into a full queue is not stalled. The word is discarded and the error and overflow flags record the event. Register map: 0 data, 1 control, 2 status, 3 interrupt pending / clear.

Top module: `spi_fifo_master`

## Requirements
- R1: With control bit 0 (enable) clear, `spi_oe` is 0, `spi_ss_n` is 1 from the next clock on, the serial clock rests at its idle level and no frame starts; words written meanwhile stay queued and go out once enable is set.
- R2: A write to address 0 queues the word for transmission. A read from address 0 returns the oldest received word and removes it, so words come back in arrival order.
- R3: A frame is 16 bits, most significant bit first, with `spi_ss_n` low from before the first clock edge until after the last. If the transmit queue still holds a word when a frame ends, the next frame follows with `spi_ss_n` held low. Otherwise `spi_ss_n` goes high.
- R4: Control bit 1 (polarity) sets the idle level of `spi_sck`: 0 rests low, 1 rests high. Whenever `spi_ss_n` is high, `spi_sck` equals this bit.
- R5: Control bit 2 (phase) selects the edges: with 0, MISO is sampled on clock edges 1, 3, ..., 31 and MOSI changes on the even edges. With 1, MISO is sampled on edges 2, 4, ..., 32 and MOSI changes on the odd edges after the first.
- R6: With control bit 3 (queue mode) set, each queue holds 8 words; with it clear, each holds 1. Status bits: 0 tx empty, 1 tx nearly empty, 2 tx full, 3 rx full, 4 rx nearly full, 5 rx empty.
- R7: In queue mode tx nearly empty (status bit 1) is 1 when the transmit queue holds 2 or fewer words. Rx nearly full (status bit 4) is 1 when the receive queue holds 6 or more. In single-word mode these bits equal tx empty and rx full.
- R8: A word pushed into a full queue is dropped and sets that queue's error flag (status bit 6 for tx, 7 for rx). Writing 1 to that bit at address 2 clears it.
- R9: The same dropped push sets the queue's overflow flag (status bit 8 for tx, 9 for rx). Writes to address 2 do not clear it; only reset does.
- R10: In queue mode an interrupt-pending bit (address 3: bit 0 tx nearly empty, 1 rx nearly full, 2 tx empty, 3 rx full) is set when its condition rises and stays set until 1 is written to that bit at address 3. `irq` is the OR of the four bits.
- R11: In single-word mode each pending bit equals its condition one clock later, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Word address 0..3 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word |
| irq | output | 1 | OR of the interrupt-pending bits |
| spi_oe | output | 1 | High while the serial pins belong to the block |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_ss_n | output | 1 | Active-low slave select |
| spi_miso | input | 1 | Serial data in |

## Verification
The receive-side error and overflow flags can only be reached by completing more frames than the receive queue holds with no reads. The bench stages eight words in the transmit queue while the engine is off and releases them all at once. It then sends one more word without draining, and the reference model drops that ninth word from its expected-receive queue by itself. The transmit-side error is reached the same way, by filling the queue with the engine off. The rising-edge latch of the interrupt bits needs a condition that falls and then rises again in queue mode. The bench gets this by queueing a word while disabled and then enabling, after first clearing all pending bits.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef struct packed {
    logic fifo_mode;
    logic cpha;
    logic cpol;
    logic enable;
  } ctrl_t;

  localparam logic [1:0] ADDR_DATA   = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_PEND   = 2'd3;

  localparam int ST_TX_ERR = 6;
  localparam int ST_RX_ERR = 7;
endpackage

// File: rtl/sff_fifo.sv
module sff_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         single,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;
  logic [CW-1:0] limit;

  assign limit   = single ? CW'(1) : CAP;
  assign full    = (count >= limit);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);

  assert_drop_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));
endmodule

// File: rtl/sff_shifter.sv
module sff_shifter #(
  parameter int W       = 16,
  parameter int CLK_DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_word,
  input  logic         miso,
  output logic         tx_pop,
  output logic         rx_push,
  output logic [W-1:0] rx_word,
  output logic         sck,
  output logic         mosi,
  output logic         ss_n
);
  localparam int EDGES = 2 * W;
  localparam int ECW   = $clog2(EDGES + 1);
  localparam int DW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0]  DIV_LAST = DW'(CLK_DIV - 1);
  localparam logic [ECW-1:0] E_LAST   = ECW'(EDGES);
  localparam logic [ECW-1:0] E_FIRST  = ECW'(1);

  logic           active, sck_int;
  logic [DW-1:0]  div_cnt;
  logic [ECW-1:0] edge_cnt, nxt_edge;
  logic [W-1:0]   tx_sh, rx_sh;
  logic           tick, end_tick, start, sample_edge, shift_ok;

  assign tick        = en && active && (div_cnt == DIV_LAST);
  assign end_tick    = tick && (edge_cnt == E_LAST);
  assign start       = en && !active && tx_valid;
  assign nxt_edge    = edge_cnt + 1'b1;
  assign sample_edge = nxt_edge[0] ^ cpha;
  assign shift_ok    = cpha ? (nxt_edge != E_FIRST) : (nxt_edge != E_LAST);

  assign tx_pop  = start || (end_tick && tx_valid);
  assign rx_push = end_tick;
  assign rx_word = rx_sh;
  assign sck     = sck_int ^ cpol;
  assign mosi    = tx_sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      ss_n     <= 1'b1;
      sck_int  <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (!en) begin
      active   <= 1'b0;
      ss_n     <= 1'b1;
      sck_int  <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
    end else if (!active) begin
      if (tx_valid) begin
        active   <= 1'b1;
        ss_n     <= 1'b0;
        tx_sh    <= tx_word;
        div_cnt  <= '0;
        edge_cnt <= '0;
        sck_int  <= 1'b0;
      end
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (end_tick) begin
        edge_cnt <= '0;
        if (tx_valid) begin
          tx_sh <= tx_word;
        end else begin
          active <= 1'b0;
          ss_n   <= 1'b1;
        end
      end else if (tick) begin
        edge_cnt <= nxt_edge;
        sck_int  <= ~sck_int;
        if (sample_edge)   rx_sh <= {rx_sh[W-2:0], miso};
        else if (shift_ok) tx_sh <= {tx_sh[W-2:0], 1'b0};
      end
    end
  end

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> (sck == cpol));

  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ss_n);
endmodule

// File: rtl/sff_irq.sv
module sff_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fifo_mode,
  input  logic [N-1:0] cond,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] pend
);
  logic [N-1:0] cond_q, clr_mask;

  assign clr_mask = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      pend   <= '0;
    end else begin
      cond_q <= cond;
      if (!fifo_mode) pend <= cond;
      else            pend <= (pend | (cond & ~cond_q)) & ~clr_mask;
    end
  end

  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && clr_we && (clr_bits != '0)) |=> ((pend & $past(clr_bits)) == '0));

  assert_level_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> (pend == $past(cond)));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int WORD_W         = 16,
  parameter int FIFO_DEPTH     = 8,
  parameter int CLK_DIV        = 2,
  parameter int NEAR_EMPTY_LVL = 2,
  parameter int NEAR_FULL_LVL  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq,
  output logic              spi_oe,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              spi_ss_n,
  input  logic              spi_miso
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [CW-1:0] NE_LVL = CW'(NEAR_EMPTY_LVL);
  localparam logic [CW-1:0] NF_LVL = CW'(NEAR_FULL_LVL);

  ctrl_t             ctrl;
  logic              wr_data, rd_data, wr_ctrl, wr_stat, wr_pend;
  logic              tx_pop, tx_full, tx_empty, tx_drop;
  logic              rx_push, rx_full, rx_empty, rx_drop;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic              tx_near_empty, rx_near_full;
  logic              tx_err, rx_err, tx_ovf, rx_ovf;
  logic [3:0]        pend;
  logic [9:0]        status;

  assign wr_data = bus_en && bus_we && (bus_addr == ADDR_DATA);
  assign rd_data = bus_en && !bus_we && (bus_addr == ADDR_DATA);
  assign wr_ctrl = bus_en && bus_we && (bus_addr == ADDR_CTRL);
  assign wr_stat = bus_en && bus_we && (bus_addr == ADDR_STATUS);
  assign wr_pend = bus_en && bus_we && (bus_addr == ADDR_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      tx_err <= 1'b0;
      rx_err <= 1'b0;
      tx_ovf <= 1'b0;
      rx_ovf <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[3:0]);
      tx_err <= tx_drop || (tx_err && !(wr_stat && bus_wdata[ST_TX_ERR]));
      rx_err <= rx_drop || (rx_err && !(wr_stat && bus_wdata[ST_RX_ERR]));
      tx_ovf <= tx_ovf || tx_drop;
      rx_ovf <= rx_ovf || rx_drop;
    end
  end

  sff_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .single(!ctrl.fifo_mode),
    .push(wr_data), .wdata(bus_wdata), .pop(tx_pop), .rdata(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty), .drop(tx_drop));

  sff_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .single(!ctrl.fifo_mode),
    .push(rx_push), .wdata(rx_word), .pop(rd_data), .rdata(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty), .drop(rx_drop));

  sff_shifter #(.W(WORD_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(ctrl.enable), .cpol(ctrl.cpol), .cpha(ctrl.cpha),
    .tx_valid(!tx_empty), .tx_word(tx_head), .miso(spi_miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .sck(spi_sck), .mosi(spi_mosi), .ss_n(spi_ss_n));

  assign tx_near_empty = ctrl.fifo_mode ? (tx_cnt <= NE_LVL) : tx_empty;
  assign rx_near_full  = ctrl.fifo_mode ? (rx_cnt >= NF_LVL) : rx_full;

  sff_irq #(.N(4)) u_irq (
    .clk(clk), .rst_n(rst_n), .fifo_mode(ctrl.fifo_mode),
    .cond({rx_full, tx_empty, rx_near_full, tx_near_empty}),
    .clr_we(wr_pend), .clr_bits(bus_wdata[3:0]), .pend(pend));

  assign status = {rx_ovf, tx_ovf, rx_err, tx_err, rx_empty, rx_near_full,
                   rx_full, tx_full, tx_near_empty, tx_empty};
  assign irq    = |pend;
  assign spi_oe = ctrl.enable;

  always_comb begin
    unique case (bus_addr)
      ADDR_DATA:   bus_rdata = rx_head;
      ADDR_CTRL:   bus_rdata = WORD_W'(ctrl);
      ADDR_STATUS: bus_rdata = WORD_W'(status);
      default:     bus_rdata = WORD_W'(pend);
    endcase
  end

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf |=> tx_ovf) and (rx_ovf |=> rx_ovf));

  assert_err_with_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err |-> tx_ovf) and (rx_err |-> rx_ovf));
endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, spi_oe, spi_sck, spi_mosi, spi_ss_n;
  logic        spi_miso = 1'b0;

  int total = 0, bad = 0;
  bit done = 0;

  logic [3:0]  exp_ctrl = 4'h0;
  logic        exp_en_d = 1'b0;
  logic [15:0] tx_exp[$];
  logic [15:0] rx_exp[$];
  logic [15:0] cur_word;
  int          slv_n = 0;
  int          edge_k = 0, bit_i = 0, ss_rises = 0;
  logic [15:0] cap = '0;
  logic        prev_sck = 1'b0, prev_ss = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .spi_oe(spi_oe),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n), .spi_miso(spi_miso));

  function automatic logic [15:0] slave_word(int n);
    return 16'hC3A5 ^ 16'(n * 16'h1357);
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  // Reference model of the attached slave and per-clock pin rules.
  initial cur_word = slave_word(0);
  always @(negedge clk) begin
    if (rst_n) begin
      check(spi_oe == exp_ctrl[0], "R1 oe", 16'(spi_oe), 16'(exp_ctrl[0]));
      if (!exp_en_d && !exp_ctrl[0]) check(spi_ss_n == 1'b1, "R1 ss idle", 16'(spi_ss_n), 16'h1);
      if (spi_ss_n) check(spi_sck == exp_ctrl[1], "R4 idle level", 16'(spi_sck), 16'(exp_ctrl[1]));
      if (!prev_ss && spi_ss_n) begin
        ss_rises++;
        check(edge_k == 0, "R3 ss high mid-frame", 16'(edge_k), 16'h0);
      end
      if (prev_ss && !spi_ss_n) begin
        edge_k = 0;
        bit_i  = 0;
        spi_miso = cur_word[15];
      end
      if (!spi_ss_n && spi_sck != prev_sck) begin
        edge_k++;
        if ((edge_k % 2 == 1) ^ exp_ctrl[2]) begin
          cap = {cap[14:0], spi_mosi};
          bit_i++;
          if (bit_i < 16) spi_miso = cur_word[15 - bit_i];
        end
        if (edge_k == 32) begin
          if (tx_exp.size() == 0) check(1'b0, "R3 unexpected frame", cap, 16'h0);
          else begin
            logic [15:0] e;
            e = tx_exp.pop_front();
            check(cap == e, "R3/R5 mosi word", cap, e);
          end
          if (rx_exp.size() < (exp_ctrl[3] ? 8 : 1)) rx_exp.push_back(cur_word);
          slv_n++;
          cur_word = slave_word(slv_n);
          edge_k = 0;
          bit_i  = 0;
          spi_miso = cur_word[15];
        end
      end
      exp_en_d = exp_ctrl[0];
    end
    prev_sck = spi_sck;
    prev_ss  = spi_ss_n;
  end

  task automatic bus_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    if (a == 2'd1) exp_ctrl = d[3:0];
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_en = 1'b0;
  endtask

  task automatic send(logic [15:0] w, bit accepted);
    if (accepted) tx_exp.push_back(w);
    bus_write(2'd0, w);
  endtask

  task automatic read_rx(string tag);
    logic [15:0] d, e;
    bus_read(2'd0, d);
    if (rx_exp.size() == 0) check(1'b0, tag, d, 16'hxxxx);
    else begin
      e = rx_exp.pop_front();
      check(d == e, tag, d, e);
    end
  endtask

  task automatic expect_reg(logic [1:0] a, logic [15:0] e, string tag);
    logic [15:0] d;
    bus_read(a, d);
    check(d == e, tag, d, e);
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_cycles(3);

    // Reset state, single-word mode.
    expect_reg(2'd2, 16'h0023, "R6 reset status");
    check(spi_ss_n == 1'b1 && spi_oe == 1'b0, "R1 reset pins", {spi_oe, spi_ss_n}, 16'h1);
    expect_reg(2'd3, 16'h0005, "R11 pend follows level");
    bus_write(2'd3, 16'h000F);
    wait_cycles(2);
    expect_reg(2'd3, 16'h0005, "R11 clear ignored");
    check(irq == 1'b1, "R11 irq level", 16'(irq), 16'h1);

    // Single-word transfer, format 0.
    bus_write(2'd1, 16'h0001);
    send(16'h1234, 1);
    wait_cycles(100);
    read_rx("R2 single rx word");

    // Single-word depth with engine off.
    bus_write(2'd1, 16'h0000);
    send(16'hBEEF, 1);
    send(16'hDEAD, 0);
    wait_cycles(3);
    check(spi_ss_n == 1'b1, "R1 no frame while off", 16'(spi_ss_n), 16'h1);
    expect_reg(2'd2, 16'h0164, "R6/R8 tx full and error");
    bus_write(2'd2, 16'h0040);
    expect_reg(2'd2, 16'h0124, "R9 ovf survives clear");
    bus_write(2'd1, 16'h0001);
    wait_cycles(100);
    read_rx("R1 queued word sent after enable");

    // Queue mode, all four formats, bursts of three.
    for (int m = 0; m < 4; m++) begin
      bus_write(2'd1, 16'(4'h9 | (m << 1)));
      ss_rises = 0;
      send(16'h8001 + 16'(m), 1);
      send(16'h4F20 ^ 16'(m << 4), 1);
      send(16'h00FF + 16'(m << 8), 1);
      wait_cycles(3 * 70 + 30);
      check(ss_rises == 1, "R3 ss low across burst", 16'(ss_rises), 16'h1);
      check(spi_sck == exp_ctrl[1], "R4 rest level", 16'(spi_sck), 16'(exp_ctrl[1]));
      for (int k = 0; k < 3; k++) read_rx("R5 rx word per format");
    end

    // Queue mode thresholds and tx overfill with engine off.
    bus_write(2'd1, 16'h0008);
    send(16'h1111, 1);
    send(16'h2222, 1);
    expect_reg(2'd2, 16'h0122, "R7 near empty at 2");
    send(16'h3333, 1);
    expect_reg(2'd2, 16'h0120, "R7 not near empty at 3");
    for (int k = 4; k <= 8; k++) send(16'(k * 16'h1111), 1);
    send(16'h9999, 0);
    expect_reg(2'd2, 16'h0164, "R6/R8 tx depth 8");
    bus_write(2'd2, 16'h0040);
    bus_write(2'd1, 16'h0009);
    wait_cycles(8 * 70 + 40);
    expect_reg(2'd2, 16'h011B, "R6/R7 rx full and near full");
    send(16'h5A5A, 1);
    wait_cycles(100);
    expect_reg(2'd2, 16'h039B, "R8/R9 rx drop flags");
    bus_write(2'd2, 16'h0080);
    expect_reg(2'd2, 16'h031B, "R8 rx err clear");
    read_rx("R2 drain order");
    read_rx("R2 drain order");
    expect_reg(2'd2, 16'h0313, "R7 near full at 6");
    read_rx("R2 drain order");
    expect_reg(2'd2, 16'h0303, "R7 not near full at 5");
    for (int k = 0; k < 5; k++) read_rx("R2 drain order");

    // Interrupt latch and clear in queue mode.
    bus_write(2'd3, 16'h000F);
    expect_reg(2'd3, 16'h0000, "R10 cleared");
    check(irq == 1'b0, "R10 irq low", 16'(irq), 16'h0);
    bus_write(2'd1, 16'h0008);
    send(16'h0F0F, 1);
    bus_write(2'd1, 16'h0009);
    wait_cycles(100);
    expect_reg(2'd3, 16'h0004, "R10 tx empty latched");
    check(irq == 1'b1, "R10 irq high", 16'(irq), 16'h1);
    bus_write(2'd3, 16'h0001);
    expect_reg(2'd3, 16'h0004, "R10 other bit kept");
    bus_write(2'd3, 16'h0004);
    expect_reg(2'd3, 16'h0000, "R10 w1c");
    read_rx("R2 last word");
    check(tx_exp.size() == 0, "R3 all words sent", 16'(tx_exp.size()), 16'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule